// File: doc/BRIEF.md
# Payload-Size Request Scheduler with Flush Timer

This block sits inside a streaming DMA engine and decides when the engine should send a request packet and how many bytes that packet should carry. It looks at three things: how many bytes the data buffer can supply or accept right now, how many bytes the transfer budget counter still allows, and a pair of configuration words. The first word sets a floor and a ceiling on payload size. The second word sets a flush interval and an off switch for that interval.

Requests normally wait until a payload of at least the floor size can be formed. Two things can override the floor. A budget remainder smaller than the floor is sent as it stands. A countdown timer, once it runs out, flushes whatever data is ready. The request is held with a fixed size until the packet formatter acknowledges it.

Top module: `pkt_req_sched`

## Requirements
- R1: `req_o` is low after reset. No request is raised while `xfer_en_i` is low, while `quota_bytes_i` is zero or while `ready_bytes_i` is zero.
- R2: The request size is the smallest of three values: `ready_bytes_i`, the ceiling and `quota_bytes_i`.
- R3: When flushing is off, no request is raised while the sized payload is below the floor, however long the data waits.
- R4: When `quota_bytes_i` is nonzero, below the floor and no larger than `ready_bytes_i`, a request for the remainder is raised without waiting for the floor. If ready data is below that remainder, no request is raised.
- R5: When flushing is on and data below the floor is pending, a request for all ready data is raised. It appears on the clock edge after the timer has counted down from the preload P, which is P+1 edges after the data appears.
- R6: The timer reloads P when a request is acknowledged and when no data is pending, so each pause in the data restarts the full interval.
- R7: `req_o` and `req_size_o` stay unchanged until `req_ack_i` is seen. `req_o` is low on the edge after the acknowledgment.
- R8: When the floor is above the ceiling, requests come only from the remainder rule or from a flush.
- R9: Field positions: in `size_cfg_i` the floor is bits [15:0] and the ceiling is bits [31:16]. In `flush_cfg_i` the preload is bits [9:0] and bit 31 set turns flushing off.
- R10: The request is registered: `req_o` rises on the first clock edge at which its condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_en_i | input | 1 | Transfers enabled |
| ready_bytes_i | input | AVL_W (16) | Bytes the buffer can supply or accept |
| quota_bytes_i | input | CNT_W (32) | Bytes the transfer budget still allows |
| size_cfg_i | input | 32 | Floor [15:0], ceiling [31:16] |
| flush_cfg_i | input | 32 | Preload [9:0], flush off [31] |
| req_ack_i | input | 1 | Formatter has taken the request |
| req_o | output | 1 | Request pending |
| req_size_o | output | 16 | Payload bytes of the pending request |

## Verification
The sizing rule is driven with patterns in which each of the three limits is the smallest in turn. A wrong minimum selection therefore shows up as a wrong byte count. Sub-floor data is held for long stretches with flushing off and then with flushing on, and the exact edge of the flush is sampled. This separates an off-by-one countdown from a timer that never reloads. A pause in the data in mid-countdown checks that the interval restarts in full. The inverted floor/ceiling case and the remainder case with too little ready data check that each override fires only under its own condition.

// File: rtl/prs_pkg.sv
// Package: shared config layout and decoded config type for the request scheduler.
// Assumes 32-bit configuration words whose field positions are fixed by the register block.
package prs_pkg;
    localparam int CFG_W       = 32;
    localparam int SIZE_W      = 16;
    localparam int TMR_W       = 10;
    localparam int FLOOR_LSB   = 0;
    localparam int CEIL_LSB    = 16;
    localparam int PRELOAD_LSB = 0;
    localparam int FLUSH_OFF_B = 31;

    typedef struct packed {
        logic [SIZE_W-1:0] floor_sz;
        logic [SIZE_W-1:0] ceil_sz;
        logic [TMR_W-1:0]  preload;
        logic              flush_off;
    } prs_cfg_t;

    // Split the two configuration words into named fields.
    function automatic prs_cfg_t decode_cfg(input logic [CFG_W-1:0] size_w,
                                            input logic [CFG_W-1:0] flush_w);
        prs_cfg_t c;
        c.floor_sz  = size_w[FLOOR_LSB +: SIZE_W];
        c.ceil_sz   = size_w[CEIL_LSB +: SIZE_W];
        c.preload   = flush_w[PRELOAD_LSB +: TMR_W];
        c.flush_off = flush_w[FLUSH_OFF_B];
        return c;
    endfunction
endpackage

// File: rtl/prs_size_calc.sv
// Module: combinational payload sizing.
// Works out the usable bytes, the clamped size and which request rules are met.
// Assumes AVL_W and SIZE_W are no wider than CNT_W.
module prs_size_calc #(
    parameter int AVL_W  = 16,
    parameter int CNT_W  = 32,
    parameter int SIZE_W = 16
) (
    input  logic [AVL_W-1:0]  ready_i,
    input  logic [CNT_W-1:0]  quota_i,
    input  logic [SIZE_W-1:0] floor_i,
    input  logic [SIZE_W-1:0] ceil_i,
    output logic [SIZE_W-1:0] size_o,
    output logic              pending_o,
    output logic              floor_ok_o,
    output logic              remainder_ok_o
);
    logic [CNT_W-1:0] ready_w, floor_w, ceil_w, usable_w, size_w;

    // Widen the inputs and apply the three-way minimum with the rule tests.
    always_comb begin
        ready_w        = CNT_W'(ready_i);
        floor_w        = CNT_W'(floor_i);
        ceil_w         = CNT_W'(ceil_i);
        usable_w       = (quota_i < ready_w) ? quota_i : ready_w;
        size_w         = (usable_w < ceil_w) ? usable_w : ceil_w;
        size_o         = size_w[SIZE_W-1:0];
        pending_o      = (usable_w != '0);
        floor_ok_o     = (size_w >= floor_w) && pending_o;
        remainder_ok_o = (quota_i != '0) && (quota_i < floor_w) && (ready_w >= quota_i);
    end
endmodule

// File: rtl/prs_flush_timer.sv
// Module: flush countdown timer.
// Reloads the preload on load_i, counts down while run_i holds, and stops at zero.
// Assumes load_i takes priority over run_i.
module prs_flush_timer #(
    parameter int TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] preload_i,
    input  logic             load_i,
    input  logic             run_i,
    output logic             expired_o
);
    logic [TMR_W-1:0] tmr_q;

    // Reload, count down or hold the remaining interval.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tmr_q <= preload_i;
        else if (load_i)                tmr_q <= preload_i;
        else if (run_i && tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
    end

    assign expired_o = (tmr_q == '0);

    // R6: a load leaves the preload in the timer
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> tmr_q == $past(preload_i));
    // R5: the interval does not move while the timer is neither run nor loaded
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run_i) |=> $stable(tmr_q));
endmodule

// File: rtl/prs_req_reg.sv
// Module: request holding register.
// Captures size on fire and holds request and size until acknowledged.
// Assumes fire_i is only acted on while no request is held.
module prs_req_reg #(
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              taken_o
);
    // Set on fire, clear on acknowledgment, capture size when setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            size_o <= '0;
        end else if (req_o) begin
            if (ack_i) req_o <= 1'b0;
        end else if (fire_i) begin
            req_o  <= 1'b1;
            size_o <= size_i;
        end
    end

    assign taken_o = req_o && ack_i;

    // R7: an unacknowledged request stays with the same size
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(size_o)));
    // R7: an acknowledged request is gone on the next edge
    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);
endmodule

// File: rtl/pkt_req_sched.sv
// Module: payload-size request scheduler top.
// Combines the sizing rules, the flush timer and the request register.
// Assumes ready and quota inputs are updated by the engine after each acknowledgment.
module pkt_req_sched
    import prs_pkg::*;
#(
    parameter int AVL_W = 16,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_en_i,
    input  logic [AVL_W-1:0]  ready_bytes_i,
    input  logic [CNT_W-1:0]  quota_bytes_i,
    input  logic [CFG_W-1:0]  size_cfg_i,
    input  logic [CFG_W-1:0]  flush_cfg_i,
    input  logic              req_ack_i,
    output logic              req_o,
    output logic [SIZE_W-1:0] req_size_o
);
    prs_cfg_t          cfg;
    logic [SIZE_W-1:0] size_now;
    logic              pending, floor_ok, remainder_ok, expired;
    logic              fire, tmr_load, tmr_run, taken;

    assign cfg = decode_cfg(size_cfg_i, flush_cfg_i);

    prs_size_calc #(.AVL_W(AVL_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W)) calc_i (
        .ready_i        (ready_bytes_i),
        .quota_i        (quota_bytes_i),
        .floor_i        (cfg.floor_sz),
        .ceil_i         (cfg.ceil_sz),
        .size_o         (size_now),
        .pending_o      (pending),
        .floor_ok_o     (floor_ok),
        .remainder_ok_o (remainder_ok)
    );

    // Decide firing and timer control from the rule outcomes.
    always_comb begin
        fire     = xfer_en_i && pending &&
                   (floor_ok || remainder_ok || (!cfg.flush_off && expired));
        tmr_load = taken || !pending || !xfer_en_i;
        tmr_run  = xfer_en_i && !req_o && !floor_ok && !remainder_ok;
    end

    prs_flush_timer #(.TMR_W(TMR_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .preload_i (cfg.preload),
        .load_i    (tmr_load),
        .run_i     (tmr_run),
        .expired_o (expired)
    );

    prs_req_reg #(.SIZE_W(SIZE_W)) req_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .size_i  (size_now),
        .ack_i   (req_ack_i),
        .req_o   (req_o),
        .size_o  (req_size_o),
        .taken_o (taken)
    );

    // R1: a new request only follows an enabled edge with budget and data
    a_r1_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> ($past(xfer_en_i) && $past(quota_bytes_i) != '0 && $past(ready_bytes_i) != '0));
    // R2: a new request never exceeds the ceiling or the ready data seen at its edge
    a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> (req_size_o <= $past(cfg.ceil_sz) &&
                          CNT_W'(req_size_o) <= CNT_W'($past(ready_bytes_i)) &&
                          CNT_W'(req_size_o) <= $past(quota_bytes_i)));
    // R3: with flushing off, a new request meets the floor or the remainder rule
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_o) && $past(cfg.flush_off)) |-> ($past(floor_ok) || $past(remainder_ok)));
endmodule

// File: tb/pkt_req_sched_tb.sv
// Bench: directed scenarios for the request scheduler, one task per scenario.
module pkt_req_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_en = 1'b0;
    logic [15:0] ready = '0;
    logic [31:0] quota = '0;
    logic [31:0] size_cfg = '0;
    logic [31:0] flush_cfg = '0;
    logic        ack = 1'b0;
    logic        req;
    logic [15:0] req_size;
    int          n_checks = 0;
    int          n_errors = 0;

    always #2 clk = ~clk;

    pkt_req_sched dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_en_i(xfer_en), .ready_bytes_i(ready),
        .quota_bytes_i(quota), .size_cfg_i(size_cfg), .flush_cfg_i(flush_cfg),
        .req_ack_i(ack), .req_o(req), .req_size_o(req_size)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int floor_sz, input int ceil_sz, input int pre, input bit off);
        size_cfg  = {ceil_sz[15:0], floor_sz[15:0]};
        flush_cfg = {off, 21'b0, pre[9:0]};
    endtask

    // Acknowledge a held request and clear the data so nothing refires.
    task automatic take(input string tag);
        ack = 1'b1; ready = '0;
        tick(1);
        chk({tag, " R7 drop after ack"}, req, 0);
        ack = 1'b0;
        tick(1);
    endtask

    task automatic t_reset;
        chk("R1 reset req low", req, 0);
    endtask

    task automatic t_floor_wait;
        set_cfg(64, 256, 10, 1); xfer_en = 1; quota = 1000; ready = 32;
        tick(50);
        chk("R3 below floor no req", req, 0);
        ready = 100;
        tick(1);
        chk("R10 req one edge later", req, 1);
        chk("R2 size is ready", req_size, 100);
        ready = 200;
        tick(3);
        chk("R7 req held", req, 1);
        chk("R7 size held", req_size, 100);
        take("floor");
    endtask

    task automatic t_clamps;
        set_cfg(64, 256, 10, 1); quota = 1000; ready = 1000;
        tick(1);
        chk("R2 ceiling clamp", req_size, 256);
        chk("R9 ceiling in upper half", req, 1);
        take("ceil");
        quota = 80; ready = 500;
        tick(1);
        chk("R2 quota clamp", req_size, 80);
        take("quota");
    endtask

    task automatic t_remainder;
        set_cfg(64, 256, 10, 1); quota = 20; ready = 10;
        tick(30);
        chk("R4 too little ready no req", req, 0);
        ready = 30;
        tick(1);
        chk("R4 remainder req", req, 1);
        chk("R4 remainder size", req_size, 20);
        take("rem");
    endtask

    task automatic t_flush;
        set_cfg(64, 256, 10, 0); quota = 1000; ready = 0;
        tick(2);
        ready = 16;
        tick(10);
        chk("R5 no flush before interval", req, 0);
        tick(1);
        chk("R5 flush raised", req, 1);
        chk("R5 flush size all ready", req_size, 16);
        take("flush");
    endtask

    task automatic t_restart;
        set_cfg(64, 256, 10, 0); quota = 1000; ready = 0;
        tick(2);
        ready = 16;
        tick(6);
        ready = 0;
        tick(1);
        ready = 16;
        tick(10);
        chk("R6 interval restarted", req, 0);
        tick(1);
        chk("R6 flush after full interval", req, 1);
        take("restart");
    endtask

    task automatic t_inverted;
        set_cfg(300, 100, 10, 1); quota = 1000; ready = 500;
        tick(30);
        chk("R8 floor above ceiling no req", req, 0);
        set_cfg(300, 100, 5, 0);
        tick(1);
        chk("R8 flush still fires", req, 1);
        chk("R8 flush size ceiling", req_size, 100);
        take("inv flush");
        set_cfg(300, 100, 10, 1); quota = 50; ready = 500;
        tick(1);
        chk("R8 remainder fires", req, 1);
        chk("R8 remainder size", req_size, 50);
        take("inv rem");
    endtask

    task automatic t_gating;
        set_cfg(64, 256, 0, 0); quota = 1000; ready = 500; xfer_en = 0;
        tick(20);
        chk("R1 disabled no req", req, 0);
        xfer_en = 1; quota = 0;
        tick(20);
        chk("R1 zero quota no req", req, 0);
        quota = 1000; ready = 0;
        tick(2);
        chk("R1 zero ready no req", req, 0);
        ready = 8;
        tick(1);
        chk("R9 preload zero flush at once", req, 1);
        chk("R9 preload zero size", req_size, 8);
        take("gate");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        set_cfg(64, 256, 10, 1);
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_floor_wait();
        t_clamps();
        t_remainder();
        t_flush();
        t_restart();
        t_inverted();
        t_gating();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule